// File: doc/BRIEF.md
# Regulator Enable and Fault Sequencer

This block owns the power state of a step-down switching regulator. It qualifies the hardware enable pin, the software enable bit and the supply-above-lockout flag, and walks the converter through a fixed start delay, an output ramp, a forced-PWM calibration window and normal running. While the switcher is on, it watches a per-switching-cycle current-limit flag and an over-temperature flag. It turns these into a timed hiccup shutdown with automatic retry, or a thermal hold that waits for a separate cooled flag.

All timing uses a one-pulse-per-microsecond tick. The fault and light-load counters use a strobe that marks each switching cycle. The outputs drive the switcher enable, the ramp generator request, the calibration force-PWM line, the light-load (PFM) permission, the output pull-down and the configuration-register reset.

Top module: `reg_seq`

## Requirements
- R1: The switcher runs only while the EN pin, the software enable bit and the supply-above-lockout flag are all high. Losing any of the three sends the block to shutdown on the next clock from any state, including hiccup and thermal hold. All timers are cleared, so a later enable starts again with the full start delay.
- R2: After enabling, the block waits START_DLY_US microsecond ticks with the switcher off. It then raises both the ramp request and the switcher enable.
- R3: The ramp request stays high until ramp_done_i. The block then holds cal_pwm_o and the switcher on for CAL_US ticks with PFM permission low, and then enters run.
- R4: While the switcher is on, a trip occurs on a strobe at which the current limit is asserted after ILIM_CYC consecutive limited strobes, that is, on the (ILIM_CYC+1)th. A strobe without the limit resets the count to zero.
- R5: A trip turns the switcher off for HICCUP_US ticks. The block then restarts directly with a ramp request, without the start delay. The limit count starts fresh, so a persistent fault trips again after ILIM_CYC+1 limited strobes.
- R6: An over-temperature flag turns the switcher off on the next clock. It stays off, even after the flag drops, until the cooled flag is seen. The block then restarts with a ramp request.
- R7: dischg_o follows the discharge bit only in shutdown. It is low whenever the switcher is on and during hiccup and thermal hold.
- R8: reg_rst_o is high whenever the EN pin is low or the supply is below lockout. The software enable bit alone does not raise it.
- R9: pfm_en_o is high only in run, with the mode bit set, after DCM_CYC consecutive strobes flagged discontinuous. A strobe without the flag clears that count.
- R10: The timers advance only on microsecond ticks. With the tick held low, the start delay never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| cyc_stb_i | input | 1 | One-cycle strobe per switching cycle |
| en_pin_i | input | 1 | Hardware enable pin |
| sw_en_i | input | 1 | Software enable bit |
| uvlo_ok_i | input | 1 | Supply above lockout threshold |
| ot_hot_i | input | 1 | Over-temperature flag |
| ot_cool_i | input | 1 | Die cooled below hysteresis threshold |
| ilim_i | input | 1 | Current limit hit in this switching cycle |
| dcm_i | input | 1 | Inductor current discontinuous in this cycle |
| ramp_done_i | input | 1 | Ramp reached setpoint |
| pfm_allow_i | input | 1 | Mode bit permitting PFM |
| dis_en_i | input | 1 | Output discharge bit |
| sw_on_o | output | 1 | Switcher enable |
| ramp_req_o | output | 1 | Start-ramp request |
| cal_pwm_o | output | 1 | Force-PWM calibration window |
| pfm_en_o | output | 1 | PFM permitted |
| dischg_o | output | 1 | Output pull-down enable |
| reg_rst_o | output | 1 | Register reset request |

## Verification
The assertions check properties that hold on every cycle:
- a disqualified enable or an over-temperature flag is followed by a switcher that is off;
- ramp request, calibration and PFM permission are mutually exclusive;
- discharge never overlaps switching;
- PFM permission implies the mode bit;
- a register reset is followed by shutdown.

Only the bench's directed scenarios can show exact counts. These are the start-delay and calibration lengths, the trip on the (ILIM_CYC+1)th limited strobe, and the reset of that count by one clean cycle. They also include the hiccup length and its retry without a start delay, and the need for the cooled flag before a thermal restart.

// File: rtl/reg_seq_pkg.sv
package reg_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_DLY, ST_RAMP, ST_CAL, ST_RUN, ST_HIC, ST_HOT
  } seq_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/reg_seq_tmr.sv
module reg_seq_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = tick_i && (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/reg_seq_runcnt.sv
module reg_seq_runcnt #(
  parameter int N = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic hit_i,
  output logic full_o
);
  localparam int W = $clog2(N + 1);
  logic [W-1:0] cnt_q;

  assign full_o = (cnt_q == W'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (stb_i)  cnt_q <= !hit_i ? '0 : (full_o ? cnt_q : cnt_q + 1'b1);
  end
endmodule

// File: rtl/reg_seq.sv
module reg_seq
  import reg_seq_pkg::*;
#(
  parameter int START_DLY_US = 100,
  parameter int CAL_US       = 85,
  parameter int HICCUP_US    = 80,
  parameter int ILIM_CYC     = 32,
  parameter int DCM_CYC      = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic us_tick_i,
  input  logic cyc_stb_i,
  input  logic en_pin_i,
  input  logic sw_en_i,
  input  logic uvlo_ok_i,
  input  logic ot_hot_i,
  input  logic ot_cool_i,
  input  logic ilim_i,
  input  logic dcm_i,
  input  logic ramp_done_i,
  input  logic pfm_allow_i,
  input  logic dis_en_i,
  output logic sw_on_o,
  output logic ramp_req_o,
  output logic cal_pwm_o,
  output logic pfm_en_o,
  output logic dischg_o,
  output logic reg_rst_o
);
  localparam int TMAX = max3(START_DLY_US, CAL_US, HICCUP_US);
  localparam int TW   = $clog2(TMAX + 1);

  seq_st_e       state_q, state_d;
  logic          en_ok, active, timed;
  logic          tmr_clr, tmr_done;
  logic [TW-1:0] tmr_lim;
  logic          ilim_full, dcm_full, ilim_trip;

  assign en_ok  = en_pin_i && sw_en_i && uvlo_ok_i;
  assign active = (state_q == ST_RAMP) || (state_q == ST_CAL) || (state_q == ST_RUN);
  assign timed  = (state_q == ST_DLY) || (state_q == ST_CAL) || (state_q == ST_HIC);

  always_comb begin
    case (state_q)
      ST_DLY:  tmr_lim = TW'(START_DLY_US);
      ST_CAL:  tmr_lim = TW'(CAL_US);
      ST_HIC:  tmr_lim = TW'(HICCUP_US);
      default: tmr_lim = '1;
    endcase
  end

  assign tmr_clr = (state_d != state_q) || !timed;

  reg_seq_tmr #(.W(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (tmr_clr),
    .tick_i (us_tick_i), .lim_i (tmr_lim), .done_o (tmr_done)
  );

  // over-current run length, only counted while switching
  reg_seq_runcnt #(.N(ILIM_CYC)) u_ilim (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (!active),
    .stb_i (cyc_stb_i), .hit_i (ilim_i), .full_o (ilim_full)
  );

  // light-load run length, only counted in run
  reg_seq_runcnt #(.N(DCM_CYC)) u_dcm (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (state_q != ST_RUN),
    .stb_i (cyc_stb_i), .hit_i (dcm_i), .full_o (dcm_full)
  );

  assign ilim_trip = active && cyc_stb_i && ilim_i && ilim_full;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:  if (en_ok)       state_d = ST_DLY;
      ST_DLY:  if (tmr_done)    state_d = ST_RAMP;
      ST_RAMP: if (ramp_done_i) state_d = ST_CAL;
      ST_CAL:  if (tmr_done)    state_d = ST_RUN;
      ST_HIC:  if (tmr_done)    state_d = ST_RAMP;
      ST_HOT:  if (ot_cool_i)   state_d = ST_RAMP;
      default: ;
    endcase
    if (ilim_trip) state_d = ST_HIC;
    if (ot_hot_i && state_q != ST_HOT) state_d = ST_HOT;
    if (!en_ok) state_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign sw_on_o    = active;
  assign ramp_req_o = (state_q == ST_RAMP);
  assign cal_pwm_o  = (state_q == ST_CAL);
  assign pfm_en_o   = (state_q == ST_RUN) && pfm_allow_i && dcm_full;
  assign dischg_o   = (state_q == ST_OFF) && dis_en_i;
  assign reg_rst_o  = !(en_pin_i && uvlo_ok_i);
endmodule

// File: rtl/reg_seq_chk.sv
module reg_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_pin_i,
  input logic sw_en_i,
  input logic uvlo_ok_i,
  input logic ot_hot_i,
  input logic pfm_allow_i,
  input logic sw_on_o,
  input logic ramp_req_o,
  input logic cal_pwm_o,
  input logic pfm_en_o,
  input logic dischg_o,
  input logic reg_rst_o
);
  a_r1_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_pin_i && sw_en_i && uvlo_ok_i) |=> !sw_on_o && !ramp_req_o && !cal_pwm_o);

  a_r6_hot_turns_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_hot_i |=> !sw_on_o);

  a_r3_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ramp_req_o, cal_pwm_o, pfm_en_o}));

  a_r3_cal_switching: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_pwm_o |-> sw_on_o);

  a_r7_no_dischg_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dischg_o |-> !sw_on_o);

  a_r9_pfm_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfm_en_o |-> pfm_allow_i && sw_on_o);

  a_r8_rst_means_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |=> !sw_on_o);
endmodule

bind reg_seq reg_seq_chk u_chk (.*);

// File: tb/reg_seq_bench.sv
module reg_seq_bench;
  localparam int TCK  = 10;
  localparam int DLY  = 5;
  localparam int CAL  = 4;
  localparam int HIC  = 6;
  localparam int ILIM = 4;
  localparam int DCM  = 3;

  logic clk = 0, rst_n = 0;
  logic tick = 1, stb = 1, en_pin = 0, sw_en = 0, uvlo = 0;
  logic hot = 0, cool = 0, ilim = 0, dcm = 0, rdone = 0, pallow = 0, dis = 1;
  logic sw_on, ramp, cal, pfm, dischg, rrst;
  int checks = 0, errs = 0;

  always #(TCK/2) clk = ~clk;

  reg_seq #(.START_DLY_US(DLY), .CAL_US(CAL), .HICCUP_US(HIC),
            .ILIM_CYC(ILIM), .DCM_CYC(DCM)) u_reg_seq (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .cyc_stb_i(stb),
    .en_pin_i(en_pin), .sw_en_i(sw_en), .uvlo_ok_i(uvlo), .ot_hot_i(hot),
    .ot_cool_i(cool), .ilim_i(ilim), .dcm_i(dcm), .ramp_done_i(rdone),
    .pfm_allow_i(pallow), .dis_en_i(dis), .sw_on_o(sw_on), .ramp_req_o(ramp),
    .cal_pwm_o(cal), .pfm_en_o(pfm), .dischg_o(dischg), .reg_rst_o(rrst));

  task automatic chk(input string r, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s act=%0b exp=%0b", r, a, e);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset sw_on", sw_on, 0);
    chk("R7 reset dischg", dischg, 1);
    chk("R8 reset reg_rst", rrst, 1);
  endtask

  task automatic t_start;
    tick = 0;
    en_pin = 1; sw_en = 1; uvlo = 1;
    #1 chk("R8 reg_rst released", rrst, 0);
    nclk(DLY + 6);
    chk("R10 no tick no ramp", ramp, 0);
    tick = 1;
    nclk(DLY - 1);
    chk("R2 delay ramp low", ramp, 0);
    chk("R2 delay sw off", sw_on, 0);
    nclk(1);
    chk("R2 ramp req", ramp, 1);
    chk("R2 sw on", sw_on, 1);
  endtask

  task automatic t_cal_pfm;
    pallow = 1; dcm = 1;
    nclk(3);
    chk("R3 ramp held", ramp, 1);
    rdone = 1;
    nclk(1);
    rdone = 0;
    chk("R3 cal on", cal, 1);
    chk("R3 ramp drop", ramp, 0);
    nclk(CAL - 1);
    chk("R3 cal held", cal, 1);
    chk("R3 no pfm in cal", pfm, 0);
    nclk(1);
    chk("R3 cal end", cal, 0);
    chk("R9 pfm not yet", pfm, 0);
    nclk(DCM - 1);
    chk("R9 pfm count short", pfm, 0);
    nclk(1);
    chk("R9 pfm on", pfm, 1);
    dcm = 0;
    nclk(1);
    chk("R9 ccm clears", pfm, 0);
    dcm = 1;
    nclk(DCM - 1);
    chk("R9 recount short", pfm, 0);
    nclk(1);
    chk("R9 recount on", pfm, 1);
    pallow = 0;
    #1 chk("R9 mode bit low", pfm, 0);
    dcm = 0;
  endtask

  task automatic t_ilim;
    ilim = 1;
    nclk(ILIM);
    ilim = 0;
    nclk(1);
    ilim = 1;
    nclk(ILIM);
    chk("R4 clean cycle reset count", sw_on, 1);
    nclk(1);
    chk("R4 trip", sw_on, 0);
    chk("R7 no dischg in hiccup", dischg, 0);
    nclk(HIC - 1);
    chk("R5 hiccup held", sw_on, 0);
    nclk(1);
    chk("R5 restart sw", sw_on, 1);
    chk("R5 restart ramp", ramp, 1);
    nclk(ILIM);
    chk("R5 retry before trip", sw_on, 1);
    nclk(1);
    chk("R5 retry trip", sw_on, 0);
  endtask

  task automatic t_disable;
    sw_en = 0;
    nclk(1);
    chk("R1 off from hiccup", sw_on, 0);
    chk("R7 dischg in off", dischg, 1);
    chk("R8 sw bit no reg_rst", rrst, 0);
    ilim = 0;
    nclk(HIC + 3);
    chk("R1 stays off", sw_on, 0);
    sw_en = 1;
    nclk(DLY);
    chk("R1 full delay again", ramp, 0);
    nclk(1);
    chk("R1 ramp after delay", ramp, 1);
  endtask

  task automatic t_hot;
    hot = 1;
    nclk(1);
    chk("R6 hot off", sw_on, 0);
    nclk(3);
    hot = 0;
    nclk(3);
    chk("R6 wait cool", sw_on, 0);
    cool = 1;
    nclk(1);
    cool = 0;
    chk("R6 restart ramp", ramp, 1);
  endtask

  task automatic t_uvlo;
    dis = 0;
    uvlo = 0;
    #1 chk("R8 uvlo reg_rst", rrst, 1);
    nclk(1);
    chk("R1 uvlo off", sw_on, 0);
    chk("R7 dischg bit clear", dischg, 0);
  endtask

  initial begin
    #(TCK * 200000);
    errs++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    nclk(2);
    t_reset;
    rst_n = 1;
    nclk(1);
    t_start;
    t_cal_pfm;
    t_ilim;
    t_disable;
    t_hot;
    t_uvlo;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule